// File: doc/BRIEF.md
# Range-Matched Translation Cache

This block is a small, fully associative cache of address translations. Each slot holds one mapping: a virtual base address, a physical base address, a power-of-two span, and four attribute bits (writable, user-accessible, global, uncacheable). Slots may cover different spans at the same time, so a 4 KiB mapping can sit next to a 2 MiB one. A lookup compares the request address against every slot's range in parallel. One cycle later it reports hit or miss, the translated physical address and the attributes, and a fault code from the privilege and write-permission checks.

After a miss, the caller fetches the mapping elsewhere and presents it on the insert port. The block fills an empty slot if one exists. Otherwise it overwrites the least recently used mapping. Recency is kept as a move-to-front order, held in one small age counter per slot. A lookup may choose whether or not to refresh that order. Three maintenance operations remove mappings: drop everything, drop every mapping not marked global, and drop the mapping that covers one given address.

Top module: `xlat_cache`

## Requirements
- R1: A slot covers address A when it is valid and base <= A < base + 2^lg, where lg is the slot's span exponent. When no valid slot covers the lookup address, the response shows rsp_hit=0 with rsp_pa, rsp_fault, rsp_nc, rsp_wr and rsp_user all 0. The upper bound is exclusive.
- R2: The response appears on the clock edge that samples lk_valid, marked by rsp_valid. rsp_pa equals the slot's physical base ORed with (lookup address AND (2^lg - 1)). rsp_nc, rsp_wr and rsp_user repeat the slot's uncacheable, writable and user bits.
- R3: A hitting lookup with lk_touch=1 makes the hit slot the most recent. With lk_touch=0, the recency order is left unchanged.
- R4: An insert goes into the lowest-numbered empty slot while one exists, and evicts nothing. When every slot is full, it overwrites the least recently used slot. The inserted mapping becomes the most recent.
- R5: mnt_op=2'b01 (flush all) empties every slot in one cycle.
- R6: mnt_op=2'b10 (flush non-global) empties every slot whose global bit is 0 and keeps the global ones.
- R7: mnt_op=2'b11 (invalidate one) empties the lowest-numbered slot covering mnt_va, and does not change the recency of the others.
- R8: An access counts as user when lk_cpl=3 and lk_force_sup=0. A write is illegal when the slot is not writable and either the access is user or wp_en=1. rsp_fault=2'b01 when a user access hits a slot whose user bit is 0. Otherwise rsp_fault=2'b10 when lk_write=1 and the write is illegal. Otherwise rsp_fault=2'b00.
- R9: A read with lk_store_chk=1 yields rsp_fault=2'b10 whenever a write to the same slot would be illegal.
- R10: A maintenance operation (mnt_op != 2'b00) takes priority over an insert in the same cycle, and that insert is dropped. A lookup in the same cycle as a maintenance operation or an insert is answered from the contents held before that cycle.
- R11: After reset, every slot is empty and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_touch | input | 1 | Refresh recency on hit |
| lk_write | input | 1 | Access is a write |
| lk_store_chk | input | 1 | Read that must also be writable |
| lk_cpl | input | 2 | Current privilege level |
| lk_force_sup | input | 1 | Treat the access as supervisor |
| wp_en | input | 1 | Supervisor writes honour the writable bit |
| ins_valid | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual base of new mapping |
| ins_pa | input | PA_W | Physical base of new mapping |
| ins_lg | input | LG_W | Span exponent of new mapping |
| ins_wr | input | 1 | Writable bit |
| ins_user | input | 1 | User-accessible bit |
| ins_global | input | 1 | Global bit |
| ins_nc | input | 1 | Uncacheable bit |
| mnt_op | input | 2 | 00 none, 01 flush all, 10 flush non-global, 11 invalidate one |
| mnt_va | input | VA_W | Address for invalidate one |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_fault | output | 2 | Fault code |
| rsp_nc | output | 1 | Uncacheable |
| rsp_wr | output | 1 | Writable |
| rsp_user | output | 1 | User-accessible |

## Verification
The bench probes the range bounds: one byte below a base, the last byte of a span, and the first byte past it. A comparator with an inclusive upper bound, or one that ignores the span exponent, would hit where it must miss. Victim selection is tested in two ways. A no-touch lookup on the oldest slot must not save it from eviction. A fill after a selective flush must use empty slots before evicting the surviving global mapping. A design that refreshed recency on every hit, or evicted whenever inserting, would drop the wrong mapping. Each permission combination (user, force-supervisor, wp_en, store check) is driven against writable and read-only mappings, along with a same-cycle flush and insert and a lookup that races an invalidate.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N    = 4,
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int LG_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_va,
  input  logic            lk_touch,
  input  logic            lk_write,
  input  logic            lk_store_chk,
  input  logic [1:0]      lk_cpl,
  input  logic            lk_force_sup,
  input  logic            wp_en,
  input  logic            ins_valid,
  input  logic [VA_W-1:0] ins_va,
  input  logic [PA_W-1:0] ins_pa,
  input  logic [LG_W-1:0] ins_lg,
  input  logic            ins_wr,
  input  logic            ins_user,
  input  logic            ins_global,
  input  logic            ins_nc,
  input  logic [1:0]      mnt_op,
  input  logic [VA_W-1:0] mnt_va,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_fault,
  output logic            rsp_nc,
  output logic            rsp_wr,
  output logic            rsp_user
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] OP_NONE = 2'b00, OP_ALL = 2'b01, OP_NG = 2'b10, OP_ONE = 2'b11;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [N-1:0]      vld, e_wr, e_usr, e_glb, e_nc;
  logic [VA_W-1:0]   e_va [N];
  logic [PA_W-1:0]   e_pa [N];
  logic [LG_W-1:0]   e_lg [N];
  logic [IDX_W-1:0]  age  [N];
  logic [IDX_W-1:0]  rank [N];

  function automatic logic covers(input logic [VA_W-1:0] b, input logic [LG_W-1:0] lg,
                                  input logic [VA_W-1:0] a);
    logic [VA_W:0] top;
    top = {1'b0, b} + ((VA_W+1)'(1) << lg);
    return (a >= b) && ({1'b0, a} < top);
  endfunction

  logic [N-1:0]     lk_hv, mv_hv, kill, keep;
  logic [IDX_W-1:0] lk_idx, mv_idx, free_idx, victim, ins_idx;
  logic             lk_any, mv_any;
  wire              full = &vld;

  always_comb begin
    lk_idx = '0; mv_idx = '0; free_idx = '0; victim = '0;
    for (int i = N - 1; i >= 0; i--) begin
      lk_hv[i] = vld[i] && covers(e_va[i], e_lg[i], lk_va);
      mv_hv[i] = vld[i] && covers(e_va[i], e_lg[i], mnt_va);
      if (lk_hv[i]) lk_idx = IDX_W'(i);
      if (mv_hv[i]) mv_idx = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
      if (age[i] == OLDEST) victim = IDX_W'(i);
    end
  end

  assign lk_any  = |lk_hv;
  assign mv_any  = |mv_hv;
  assign ins_idx = full ? victim : free_idx;

  always_comb begin
    kill = '0;
    case (mnt_op)
      OP_ALL:  kill = '1;
      OP_NG:   kill = ~e_glb;
      OP_ONE:  if (mv_any) kill[mv_idx] = 1'b1;
      default: kill = '0;
    endcase
  end
  assign keep = vld & ~kill;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++)
        if (keep[j] && age[j] < age[i]) rank[i] = rank[i] + IDX_W'(1);
    end
  end

  wire              is_user = (lk_cpl == 2'd3) && !lk_force_sup;
  wire              bad_wr  = !e_wr[lk_idx] && (is_user || wp_en);
  wire [PA_W-1:0]   pmask   = (PA_W'(1) << e_lg[lk_idx]) - PA_W'(1);
  logic [1:0]       fault;

  always_comb begin
    fault = 2'b00;
    if (is_user && !e_usr[lk_idx])              fault = 2'b01;
    else if ((lk_write || lk_store_chk) && bad_wr) fault = 2'b10;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; e_wr <= '0; e_usr <= '0; e_glb <= '0; e_nc <= '0;
      for (int i = 0; i < N; i++) begin
        e_va[i] <= '0; e_pa[i] <= '0; e_lg[i] <= '0; age[i] <= '0;
      end
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_pa <= '0; rsp_fault <= '0;
      rsp_nc <= 1'b0; rsp_wr <= 1'b0; rsp_user <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_any;
      rsp_pa    <= lk_any ? (e_pa[lk_idx] | (PA_W'(lk_va) & pmask)) : '0;
      rsp_fault <= lk_any ? fault : 2'b00;
      rsp_nc    <= lk_any && e_nc[lk_idx];
      rsp_wr    <= lk_any && e_wr[lk_idx];
      rsp_user  <= lk_any && e_usr[lk_idx];
      if (mnt_op != OP_NONE) begin
        vld <= keep;
        for (int i = 0; i < N; i++) age[i] <= rank[i];
      end else if (ins_valid) begin
        for (int i = 0; i < N; i++)
          if (vld[i] && IDX_W'(i) != ins_idx) age[i] <= age[i] + IDX_W'(1);
        age[ins_idx]   <= '0;
        vld[ins_idx]   <= 1'b1;
        e_va[ins_idx]  <= ins_va;
        e_pa[ins_idx]  <= ins_pa;
        e_lg[ins_idx]  <= ins_lg;
        e_wr[ins_idx]  <= ins_wr;
        e_usr[ins_idx] <= ins_user;
        e_glb[ins_idx] <= ins_global;
        e_nc[ins_idx]  <= ins_nc;
      end else if (lk_valid && lk_touch && lk_any) begin
        for (int i = 0; i < N; i++)
          if (vld[i] && age[i] < age[lk_idx]) age[i] <= age[i] + IDX_W'(1);
        age[lk_idx] <= '0;
      end
    end
  end

  logic [N-1:0] age_used;
  always_comb begin
    age_used = '0;
    for (int i = 0; i < N; i++) if (vld[i]) age_used[age[i]] = 1'b1;
  end

  p_age_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(age_used) == $countones(vld));
  p_touch_front_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_touch && lk_any && mnt_op == OP_NONE && !ins_valid) |=> age[$past(lk_idx)] == '0);
  p_ins_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && mnt_op == OP_NONE && !full) |=> $countones(vld) == $past($countones(vld)) + 1);
  p_ins_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && mnt_op == OP_NONE && full) |=> &vld);
  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == OP_ALL) |=> vld == '0);
  p_flush_ng_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == OP_NG) |=> (vld & ~e_glb) == '0);
  p_inval_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == OP_ONE && mv_any) |=> !vld[$past(mv_idx)]);
  p_fault_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'b00) |-> rsp_hit);
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_touch = 0, lk_write = 0, lk_store_chk = 0, lk_force_sup = 0, wp_en = 0;
  logic [31:0] lk_va = 0, ins_va = 0, ins_pa = 0, mnt_va = 0;
  logic [1:0]  lk_cpl = 0, mnt_op = 0;
  logic        ins_valid = 0, ins_wr = 0, ins_user = 0, ins_global = 0, ins_nc = 0;
  logic [4:0]  ins_lg = 0;
  logic        rsp_valid, rsp_hit, rsp_nc, rsp_wr, rsp_user;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_fault;

  xlat_cache u_dut (.*);

  always #5 clk = ~clk;

  typedef logic [37:0] exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;

  function automatic exp_t mk(input bit h, input logic [31:0] pa, input logic [1:0] f,
                              input bit nc, input bit wr, input bit us);
    return {h, pa, f, nc, wr, us};
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t act, e;
      string t;
      act = {rsp_hit, rsp_pa, rsp_fault, rsp_nc, rsp_wr, rsp_user};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected response actual=%h expected=none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  task automatic set_look(input logic [31:0] va, input bit touch, input bit wr, input bit sc,
                          input logic [1:0] cpl, input bit fs, input bit wp,
                          input exp_t e, input string tag);
    lk_valid = 1; lk_va = va; lk_touch = touch; lk_write = wr; lk_store_chk = sc;
    lk_cpl = cpl; lk_force_sup = fs; wp_en = wp;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic set_ins(input logic [31:0] va, input logic [31:0] pa, input logic [4:0] lg,
                         input bit wr, input bit us, input bit gl, input bit nc);
    ins_valid = 1; ins_va = va; ins_pa = pa; ins_lg = lg;
    ins_wr = wr; ins_user = us; ins_global = gl; ins_nc = nc;
  endtask

  task automatic step();
    @(negedge clk);
    lk_valid = 0; ins_valid = 0; mnt_op = 2'b00;
    lk_touch = 0; lk_write = 0; lk_store_chk = 0; lk_cpl = 0; lk_force_sup = 0; wp_en = 0;
  endtask

  task automatic ins(input logic [31:0] va, input logic [31:0] pa, input logic [4:0] lg,
                     input bit wr, input bit us, input bit gl, input bit nc);
    set_ins(va, pa, lg, wr, us, gl, nc); step();
  endtask

  task automatic mnt(input logic [1:0] op, input logic [31:0] va);
    mnt_op = op; mnt_va = va; step();
  endtask

  task automatic miss(input logic [31:0] va, input string tag);
    set_look(va, 0, 0, 0, 0, 0, 0, mk(0, 0, 0, 0, 0, 0), tag); step();
  endtask

  task automatic hit(input logic [31:0] va, input logic [31:0] pa, input bit nc,
                     input bit wr, input bit us, input string tag);
    set_look(va, 0, 0, 0, 0, 0, 0, mk(1, pa, 0, nc, wr, us), tag); step();
  endtask

  task automatic acc(input logic [31:0] va, input bit wr, input bit sc, input logic [1:0] cpl,
                     input bit fs, input bit wp, input exp_t e, input string tag);
    set_look(va, 0, wr, sc, cpl, fs, wp, e, tag); step();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    miss(32'h1000, "R11 empty after reset");

    ins(32'h0000_1000, 32'h8000_0000, 12, 1, 1, 0, 0);
    ins(32'h0020_0000, 32'h4000_0000, 21, 0, 1, 1, 1);
    ins(32'h0000_5000, 32'h9000_0000, 12, 1, 0, 0, 0);
    ins(32'h0000_6000, 32'hA000_0000, 12, 1, 1, 0, 0);

    hit(32'h1234, 32'h8000_0234, 0, 1, 1, "R2 small page offset");
    miss(32'h0FFF, "R1 one below base");
    hit(32'h1FFF, 32'h8000_0FFF, 0, 1, 1, "R1 last byte of span");
    miss(32'h2000, "R1 exclusive upper bound");
    hit(32'h002A_BCDE, 32'h400A_BCDE, 1, 0, 1, "R2 large span and uncacheable");

    acc(32'h0020_0010, 1, 0, 3, 0, 0, mk(1, 32'h4000_0010, 2'b10, 1, 0, 1), "R8 user write read-only");
    acc(32'h0020_0010, 1, 0, 0, 0, 0, mk(1, 32'h4000_0010, 2'b00, 1, 0, 1), "R8 sup write wp off");
    acc(32'h0020_0010, 1, 0, 0, 0, 1, mk(1, 32'h4000_0010, 2'b10, 1, 0, 1), "R8 sup write wp on");
    acc(32'h0020_0010, 0, 1, 3, 0, 0, mk(1, 32'h4000_0010, 2'b10, 1, 0, 1), "R9 user store-check");
    acc(32'h0020_0010, 0, 1, 0, 0, 0, mk(1, 32'h4000_0010, 2'b00, 1, 0, 1), "R9 sup store-check wp off");
    acc(32'h0020_0010, 0, 0, 3, 0, 0, mk(1, 32'h4000_0010, 2'b00, 1, 0, 1), "R8 user plain read");
    acc(32'h0000_5008, 0, 0, 3, 0, 0, mk(1, 32'h9000_0008, 2'b01, 0, 1, 0), "R8 user on supervisor page");
    acc(32'h0000_5008, 0, 0, 3, 1, 0, mk(1, 32'h9000_0008, 2'b00, 0, 1, 0), "R8 force supervisor");
    acc(32'h0000_5008, 1, 0, 2, 0, 1, mk(1, 32'h9000_0008, 2'b00, 0, 1, 0), "R8 cpl2 is supervisor");

    set_look(32'h1000, 1, 0, 0, 0, 0, 0, mk(1, 32'h8000_0000, 0, 0, 1, 1), "R3 touch oldest");
    step();
    set_look(32'h0020_0000, 0, 0, 0, 0, 0, 0, mk(1, 32'h4000_0000, 0, 1, 0, 1), "R3 no-touch lookup");
    step();
    ins(32'h0000_7000, 32'hB000_0000, 12, 1, 1, 0, 0);
    miss(32'h0020_0000, "R3 untouched slot evicted");
    hit(32'h1000, 32'h8000_0000, 0, 1, 1, "R3 touched slot kept");
    hit(32'h7004, 32'hB000_0004, 0, 1, 1, "R4 new mapping present");

    mnt(2'b11, 32'h5010);
    miss(32'h5000, "R7 covering slot removed");
    hit(32'h6000, 32'hA000_0000, 0, 1, 1, "R7 other slot kept");

    ins(32'h0030_0000, 32'hC000_0000, 20, 1, 1, 1, 0);
    hit(32'h0031_2345, 32'hC001_2345, 0, 1, 1, "R4 insert into freed slot");
    hit(32'h1000, 32'h8000_0000, 0, 1, 1, "R4 free slot spares others");

    mnt(2'b10, 32'h0);
    hit(32'h0031_2345, 32'hC001_2345, 0, 1, 1, "R6 global kept");
    miss(32'h7000, "R6 non-global removed");
    miss(32'h1000, "R6 non-global removed");
    miss(32'h6000, "R6 non-global removed");

    ins(32'h8000, 32'hD000_0000, 12, 1, 1, 0, 0);
    ins(32'h9000, 32'hD100_0000, 12, 1, 1, 0, 0);
    ins(32'hA000, 32'hD200_0000, 12, 1, 1, 0, 0);
    hit(32'h0030_0000, 32'hC000_0000, 0, 1, 1, "R4 empty slots used first");
    ins(32'hB000, 32'hD300_0000, 12, 1, 1, 0, 0);
    miss(32'h0030_0000, "R4 full evicts least recent");
    hit(32'h8010, 32'hD000_0010, 0, 1, 1, "R4 younger slot kept");

    mnt_op = 2'b01;
    set_ins(32'hC000, 32'hE000_0000, 12, 1, 1, 1, 0);
    step();
    miss(32'hC000, "R10 insert dropped under flush");
    miss(32'h8000, "R5 flush all");
    miss(32'hB000, "R5 flush all");

    ins(32'hD000, 32'hF000_0000, 12, 1, 1, 0, 0);
    mnt_op = 2'b11; mnt_va = 32'hD000;
    set_look(32'hD000, 0, 0, 0, 0, 0, 0, mk(1, 32'hF000_0000, 0, 0, 1, 1), "R10 lookup sees old state");
    step();
    miss(32'hD000, "R7 invalidate applied");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL missing responses actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule